// File: doc/BRIEF.md
# Two-Pulse, One-Sawtooth Expansion Sound Generator

This block is a small sound source that sits on a processor's byte-wide write bus. It advances one tick on every clock, which is meant to be the CPU cycle. It has three voices: two square-wave voices with a programmable duty and a programmable level, and one ramp voice. The ramp voice sums a programmable rate into an accumulator and restarts after a fixed number of steps. Each voice has its own 12-bit period counter, which sets how often that voice takes a step. The three 4- and 5-bit voice levels are turned into signed values by linear arithmetic. They are then combined, divided down and saturated into one registered signed 16-bit sample.

Software writes the voice registers with plain byte writes. The address decoder looks only at the upper nibble and the two lowest address bits. A static strap input, `swap_lines`, exchanges the two lowest address bits before decoding. This suits boards that wire those lines crossed.

Top module: `exp_audio_synth`

## Requirements
- R1: A write is decoded from wr_addr[15:12] and the two low address bits only. Nibble 9 selects square voice 0, nibble A selects square voice 1 and nibble B selects the ramp voice. Within each voice, low bits 0, 1 and 2 select the control byte, the low period byte and the high period byte. Address bits 11:2 have no effect.
- R2: While swap_lines is 1, wr_addr[0] and wr_addr[1] are exchanged before decoding.
- R3: Square voice control byte: bit 7 is force-high, bits 6:4 are the duty (0..7) and bits 3:0 are the volume. Low period byte: period bits 7:0. High period byte: bits 3:0 are period bits 11:8 and bit 7 is the voice enable. Each period byte replaces only its own period bits. The ramp voice control byte holds the rate in bits 5:0. Its period and enable bytes use the same layout as the square voices.
- R4: Each period counter starts at 0 and decrements on every tick, wrapping from 0 to 4095. A tick on which it would reach 0 is a step, and on that tick it reloads with the period. From reset, a voice's first step is therefore on tick 4096, and later steps follow every P ticks for a period P of 1 or more.
- R5: On each step a square voice increments a 4-bit step count that wraps at 16. Its output becomes the volume if force-high is 1 or the new count is below the duty; otherwise its output becomes 0. Between steps the output holds.
- R6: A voice whose enable is 0 outputs level 0 from the next tick onward.
- R7: The ramp voice uses an 8-bit accumulator that wraps and a step phase from 0 to 13. On a step in an even phase it adds the rate. On a step in phase 13 it clears the accumulator. Its output, updated every tick, is accumulator bits 7:3.
- R8: The sample register holds (2048·a + 2048·b + 1024·s − 46592) / 6, truncated toward zero and saturated to signed 16 bits. Here a and b are the square levels and s is the ramp level, all as they stood one tick earlier.
- R9: Reset clears every register, counter, phase and voice output to 0, so the sample reads −7765.
- R10: A write to low bits 3 of nibbles 9, A or B, or to any other nibble, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_lines | input | 1 | Exchange address bits 0 and 1 before decoding |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| sample | output | 16 | Signed mixed sample |

## Verification
Steps of the three voices often fall on the same tick, because their periods share common multiples: 2, 3 and 5, or 1 with 7 and 4. On those ticks one sample update must take in two or three voice changes at once. The bench checks every tick across a window of several hundred ticks and compares each sample with a mix it works out from tick arithmetic alone. A voice that lags, doubles or drops a step on a shared tick therefore shows up as a sample error at that tick.

// File: rtl/eas_pkg.sv
package eas_pkg;
  localparam int PER_W      = 12;
  localparam int VOL_W      = 4;
  localparam int DUTY_W     = 3;
  localparam int STEP_W     = 4;
  localparam int RATE_W     = 6;
  localparam int ACC_W      = 8;
  localparam int SAW_W      = 5;
  localparam int SMP_W      = 16;
  localparam int SAW_PHASES = 14;
  localparam int PULSE_BASE = -15360;
  localparam int PULSE_STEP = 2048;
  localparam int SAW_BASE   = -15872;
  localparam int SAW_STEP   = 1024;
  localparam int MIX_DIV    = 6;
  localparam int SMP_MAX    = 2 ** (SMP_W - 1) - 1;
  localparam int SMP_MIN    = -(2 ** (SMP_W - 1));

  function automatic int pulse_level(input logic [VOL_W-1:0] n);
    return PULSE_BASE + PULSE_STEP * int'(n);
  endfunction

  function automatic int saw_level(input logic [SAW_W-1:0] n);
    return SAW_BASE + SAW_STEP * int'(n);
  endfunction

  // Sum of the three mapped levels, divided (toward zero) and saturated.
  function automatic logic signed [SMP_W-1:0] mix3(input logic [VOL_W-1:0] a,
                                                   input logic [VOL_W-1:0] b,
                                                   input logic [SAW_W-1:0] s);
    int sum;
    int q;
    sum = pulse_level(a) + pulse_level(b) + saw_level(s);
    q = sum / MIX_DIV;
    if (q > SMP_MAX) q = SMP_MAX;
    else if (q < SMP_MIN) q = SMP_MIN;
    return q[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/eas_divider.sv
module eas_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period,
  output logic         step
);
  logic [W-1:0] count;
  logic [W-1:0] dec;

  assign dec  = count - W'(1);
  assign step = (dec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= step ? period : dec;
  end

  AST_RELOAD_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(period)); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> count == $past(count) - W'(1)); // R4
endmodule

// File: rtl/eas_regdec.sv
module eas_regdec #(
  parameter int         NCH  = 3,
  parameter int         REGS = 3,
  parameter logic [3:0] BASE = 4'h9
) (
  input  logic                wr_en,
  input  logic [15:0]         addr,
  input  logic                swap,
  output logic [NCH*REGS-1:0] stb
);
  logic [1:0] sel;
  logic       unused_mid;

  assign sel        = swap ? {addr[0], addr[1]} : addr[1:0];
  assign unused_mid = ^addr[11:2];

  always_comb begin
    stb = '0;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && addr[15:12] == BASE + 4'(c) && int'(sel) < REGS)
        stb[c*REGS + int'(sel)] = 1'b1;
    end
  end
endmodule

// File: rtl/eas_pulse.sv
module eas_pulse
  import eas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       wstb,
  input  logic [7:0]       wdata,
  output logic [VOL_W-1:0] level
);
  localparam int LO_W = 8;
  localparam int HI_W = PER_W - LO_W;

  logic              force_hi;
  logic [DUTY_W-1:0] duty;
  logic [VOL_W-1:0]  vol;
  logic              on;
  logic [PER_W-1:0]  period;
  logic [STEP_W-1:0] stepc;
  logic [STEP_W-1:0] stepc_nx;
  logic              step;

  eas_divider #(.W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .period(period), .step(step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_hi <= 1'b0;
      duty     <= '0;
      vol      <= '0;
      on       <= 1'b0;
      period   <= '0;
    end else begin
      if (wstb[0]) begin
        force_hi <= wdata[7];
        duty     <= wdata[6:4];
        vol      <= wdata[3:0];
      end
      if (wstb[1]) period[LO_W-1:0] <= wdata;
      if (wstb[2]) begin
        period[PER_W-1:LO_W] <= wdata[HI_W-1:0];
        on                   <= wdata[7];
      end
    end
  end

  assign stepc_nx = stepc + STEP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepc <= '0;
      level <= '0;
    end else begin
      if (step) stepc <= stepc_nx;
      if (!on) level <= '0;
      else if (step)
        level <= (force_hi || stepc_nx < STEP_W'(duty)) ? vol : '0;
    end
  end

  AST_PULSE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> level == '0); // R6
  AST_PULSE_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (on && force_hi && step) |=> level == $past(vol)); // R5
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !step) |=> level == $past(level)); // R5
endmodule

// File: rtl/eas_saw.sv
module eas_saw
  import eas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       wstb,
  input  logic [7:0]       wdata,
  output logic [SAW_W-1:0] level
);
  localparam int LO_W = 8;
  localparam int HI_W = PER_W - LO_W;
  localparam int PH_W = $clog2(SAW_PHASES);
  localparam logic [PH_W-1:0] LAST = PH_W'(SAW_PHASES - 1);

  logic [RATE_W-1:0] rate;
  logic              on;
  logic [PER_W-1:0]  period;
  logic [PH_W-1:0]   phase, phase_nx;
  logic [ACC_W-1:0]  acc, acc_nx;
  logic              step;
  logic              unused_b6;

  assign unused_b6 = wdata[6];

  eas_divider #(.W(PER_W)) u_div (
    .clk(clk), .rst_n(rst_n), .period(period), .step(step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate   <= '0;
      on     <= 1'b0;
      period <= '0;
    end else begin
      if (wstb[0]) rate <= wdata[RATE_W-1:0];
      if (wstb[1]) period[LO_W-1:0] <= wdata;
      if (wstb[2]) begin
        period[PER_W-1:LO_W] <= wdata[HI_W-1:0];
        on                   <= wdata[7];
      end
    end
  end

  always_comb begin
    acc_nx   = acc;
    phase_nx = phase;
    if (step) begin
      if (phase == LAST) begin
        acc_nx   = '0;
        phase_nx = '0;
      end else begin
        if (!phase[0]) acc_nx = acc + ACC_W'(rate);
        phase_nx = phase + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      phase <= '0;
      level <= '0;
    end else begin
      acc   <= acc_nx;
      phase <= phase_nx;
      level <= on ? acc_nx[ACC_W-1 -: SAW_W] : '0;
    end
  end

  AST_SAW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == LAST) |=> acc == '0); // R7
  AST_SAW_ODD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase[0] && phase != LAST) |=> acc == $past(acc)); // R7
  AST_SAW_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST); // R7
  AST_SAW_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> level == '0); // R6
endmodule

// File: rtl/exp_audio_synth.sv
module exp_audio_synth
  import eas_pkg::*;
#(
  parameter logic [3:0] BASE_NIBBLE = 4'h9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    swap_lines,
  input  logic                    wr_en,
  input  logic [15:0]             wr_addr,
  input  logic [7:0]              wr_data,
  output logic signed [SMP_W-1:0] sample
);
  localparam int NPULSE = 2;
  localparam int NCH    = NPULSE + 1;
  localparam int REGS   = 3;

  logic [NCH*REGS-1:0] stb;
  logic [VOL_W-1:0]    plev [NPULSE];
  logic [SAW_W-1:0]    slev;

  eas_regdec #(.NCH(NCH), .REGS(REGS), .BASE(BASE_NIBBLE)) u_dec (
    .wr_en(wr_en), .addr(wr_addr), .swap(swap_lines), .stb(stb)
  );

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    eas_pulse u_pulse (
      .clk(clk), .rst_n(rst_n),
      .wstb(stb[g*REGS +: REGS]), .wdata(wr_data), .level(plev[g])
    );
  end

  eas_saw u_saw (
    .clk(clk), .rst_n(rst_n),
    .wstb(stb[NPULSE*REGS +: REGS]), .wdata(wr_data), .level(slev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sample <= mix3('0, '0, '0);
    else        sample <= mix3(plev[0], plev[1], slev);
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R1
  AST_MIX_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample >= -16'sd7766) && (sample <= 16'sd7766)); // R8
  AST_MIX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(plev[0]) && $stable(plev[1]) && $stable(slev)) |=> $stable(sample)); // R8
endmodule

// File: tb/test_exp_audio_synth.sv
module test_exp_audio_synth;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swap_lines = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic signed [15:0] sample;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  bit done = 0;

  // scenario configuration
  bit c_mode [2];
  int c_duty [2];
  int c_vol [2];
  bit c_en [3];
  int c_per [3];
  int s_rate;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edges++;

  exp_audio_synth i_exp_audio_synth (
    .clk(clk), .rst_n(rst_n), .swap_lines(swap_lines), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample(sample)
  );

  // steps a voice of period p has taken by tick t
  function automatic int steps_by(input int t, input int p);
    if (t < 4096) return 0;
    return (t - 4096) / p + 1;
  endfunction

  function automatic int expect_at(input int e);
    int t, n, a[2], s, m, acc, sum, q;
    t = e - 1;
    for (int k = 0; k < 2; k++) begin
      n = steps_by(t, c_per[k]);
      if (!c_en[k] || n == 0) a[k] = 0;
      else a[k] = (c_mode[k] || (n % 16) < c_duty[k]) ? c_vol[k] : 0;
    end
    m = steps_by(t, c_per[2]) % 14;
    acc = (s_rate * ((m + 1) / 2)) % 256;
    s = c_en[2] ? acc / 8 : 0;
    sum = 2048 * (a[0] + a[1]) + 1024 * s - 46592;
    q = sum / 6;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic wr(input int nib, input int rg, input int data);
    logic [1:0] b;
    b = 2'(rg);
    if (swap_lines) b = {b[0], b[1]};
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = {4'(nib), 10'(nib * 37 + rg * 91 + 5), b};
    wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at tick %0d: actual %0d expected %0d", req, edges, act, exp);
    end
  endtask

  task automatic reset_dut(input bit sw);
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    swap_lines = sw;
    repeat (3) @(negedge clk);
    edges = 0;
    check("R9 reset sample", int'(sample), -7765);
    rst_n = 1'b1;
  endtask

  task automatic program_voices();
    for (int k = 0; k < 2; k++) begin
      wr(9 + k, 0, (int'(c_mode[k]) << 7) | (c_duty[k] << 4) | c_vol[k]);
      wr(9 + k, 2, (int'(c_en[k]) << 7) | ((c_per[k] >> 8) & 15));
      wr(9 + k, 1, c_per[k] & 255);
    end
    wr(11, 0, s_rate);
    wr(11, 1, c_per[2] & 255);
    wr(11, 2, (int'(c_en[2]) << 7) | ((c_per[2] >> 8) & 15));
  endtask

  task automatic sweep(input string req, input int last);
    while (edges < 4090) @(negedge clk);
    while (edges <= last) begin
      check(req, int'(sample), expect_at(edges));
      @(negedge clk);
    end
  endtask

  initial begin
    // R3 R4 R5 R7 R8: duty sweep, all three voices active with periods 2,3,5
    for (int d = 0; d < 8; d++) begin
      reset_dut(1'b0);
      c_mode[0] = 0; c_duty[0] = d; c_vol[0] = 9; c_en[0] = 1; c_per[0] = 2;
      c_mode[1] = (d == 7); c_duty[1] = 7 - d; c_vol[1] = 15 - d; c_en[1] = 1; c_per[1] = 3;
      s_rate = 6 * d + 5; c_en[2] = 1; c_per[2] = 5;
      program_voices();
      sweep("R3 R4 R5 R7 R8 duty sweep", 4096 + 250);
    end
    // R2: swapped address lines, rate overflow of the ramp (R7)
    reset_dut(1'b1);
    c_mode[0] = 1; c_duty[0] = 0; c_vol[0] = 4; c_en[0] = 1; c_per[0] = 7;
    c_mode[1] = 0; c_duty[1] = 5; c_vol[1] = 12; c_en[1] = 1; c_per[1] = 1;
    s_rate = 63; c_en[2] = 1; c_per[2] = 4;
    program_voices();
    sweep("R2 R7 swapped lines", 4096 + 200);
    // R6 disabled voices, R10 unmapped writes, R1 mid address bits ignored
    reset_dut(1'b0);
    c_mode[0] = 1; c_duty[0] = 7; c_vol[0] = 15; c_en[0] = 0; c_per[0] = 2;
    c_mode[1] = 0; c_duty[1] = 3; c_vol[1] = 7; c_en[1] = 1; c_per[1] = 2;
    s_rate = 40; c_en[2] = 0; c_per[2] = 3;
    program_voices();
    for (int n = 0; n < 16; n++) begin
      if (n >= 9 && n <= 11) wr(n, 3, 255);
      else for (int r = 0; r < 3; r++) wr(n, r, 255);
    end
    sweep("R6 R10 R1 disabled and unmapped", 4096 + 120);
    // R3 R4: period with upper bits, high byte written before low byte
    reset_dut(1'b0);
    c_mode[0] = 0; c_duty[0] = 7; c_vol[0] = 11; c_en[0] = 1; c_per[0] = 258;
    c_mode[1] = 0; c_duty[1] = 0; c_vol[1] = 0; c_en[1] = 0; c_per[1] = 1;
    s_rate = 9; c_en[2] = 1; c_per[2] = 240;
    program_voices();
    sweep("R3 R4 long period", 4096 + 258 * 17);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule